// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer Counter Channel

A single 16-bit counter channel. Its count enable and count direction come from an eight-way mode selector. The selector combines a primary source with a secondary input pin. The primary source is one of several things: one of four input pins, one of four sibling-counter compare outputs, or a free-running prescaler that divides the block clock by a power of two from 1 to 128. All pin inputs pass through a two-flop synchronizer. Edges are found by comparing the synchronized value against its registered previous value.

Counting up runs toward compare register 1; counting down runs toward compare register 2. A step taken while the counter equals the active compare value reloads the counter from the load register instead of stepping it. Both compare registers can optionally be refreshed from preload registers on a match. Compare, overflow and secondary-edge events set sticky status flags. The flags are cleared by writing ones, and each flag has its own interrupt enable. A debug request can halt counting and can force the compare output low. The compare output is a one-cycle pulse that sibling channels can use as a cascade or clock source.

The register port is a synchronous write strobe with a combinational read of the addressed register. Address map:

| Address | Register |
|---|---|
| 0 | control |
| 1 | compare 1 |
| 2 | compare 2 |
| 3 | load |
| 4 | counter |
| 5 | preload 1 |
| 6 | preload 2 |
| 7 | status |

Top module: `mtc_channel`

## Requirements
- R1: After reset the following all read 0: control, both compare registers, load, counter, both preload registers, flags and enables. `irq` and `cmp_out` are also low.
- R2: Control bit fields are: [2:0] mode, [6:3] primary source, [8:7] secondary pin, [9] count down, [11:10] debug action, [13:12] preload control. With mode 0 the counter never changes except through a bus write to it. Writing mode 0 leaves all other control fields as written.
- R3: Primary codes 0–3 select a synchronized input pin, and codes 4–7 select sibling input 0–3. Code 8+k gives one event every 2^k clocks from a free-running prescaler.
- R4: Mode 1 counts rising primary edges and mode 2 counts both primary edges. Mode 3 counts rising primary edges only while the secondary pin is high. A pin change takes effect in the counter two clocks after it is first sampled.
- R5: Mode 4 decodes quadrature on the {primary, secondary} pair. The order 00→10→11→01→00 counts up and the reverse order counts down. A change of both bits at once is ignored.
- R6: Mode 5 counts rising primary edges. The count goes down while the secondary pin is high and up while it is low.
- R7: Mode 6 waits for a rising secondary edge, then counts rising primary edges. It stops again after the step that matches the compare value.
- R8: Mode 7 (cascade) steps once on every clock in which the selected primary source is high, in the configured direction.
- R9: A step taken while the counter equals compare 1 (up) or compare 2 (down) loads the load register and sets flag 0 plus flag 1 (up) or flag 2 (down). A non-matching step from FFFF up or from 0 down wraps the counter and sets flag 3.
- R10: Preload control 1 copies both preload registers into the compare registers on an up match. Preload control 2 does the same on a down match. Preload control 0 never copies.
- R11: Status bits [4:0] are the flags: compare, compare 1, compare 2, overflow, and rising edge on the secondary pin. Writing 1 to a flag bit clears it, but a new event in the same cycle wins. Bits [12:8] are the per-flag enables. `irq` is high while any enabled flag is set.
- R12: With `dbg_req` high, debug action bit 0 stops counting. Debug action bit 1 forces `cmp_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | block clock |
| rst_n | input | 1 | asynchronous active-low reset |
| wr_en | input | 1 | register write strobe |
| addr | input | 3 | register address |
| wdata | input | 16 | write data |
| rdata | output | 16 | read data of addressed register |
| pin_in | input | 4 | asynchronous input pins |
| sib_in | input | 4 | compare outputs of sibling counters |
| dbg_req | input | 1 | debug halt request |
| cmp_out | output | 1 | one-cycle compare-match pulse |
| irq | output | 1 | interrupt request |

## Verification
The hardest case to reach is quadrature decoding with an illegal double transition. The pins pass through two synchronizer stages, so both bits must change in the same sampling cycle. The stimulus walks the pin pair through the Gray order one state at a time, with several idle clocks between steps. It then flips both pins together. A behavioural model decodes the same pair by position in the Gray cycle and is compared with the read port on every clock. Triggered mode is reached in a similar way: the counter is left idle for a while, and only then is the secondary pin given a rising edge.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  localparam int PIN_N  = 4;
  localparam int SIB_N  = 4;
  localparam int DIV_N  = 8;
  localparam int FLAG_N = 5;

  localparam int F_CMP  = 0;
  localparam int F_CMP1 = 1;
  localparam int F_CMP2 = 2;
  localparam int F_OVF  = 3;
  localparam int F_EDGE = 4;

  localparam int IE_LSB = 8;

  typedef enum logic [2:0] {
    M_OFF, M_RISE, M_BOTH, M_GATED, M_QUAD, M_DIRSEC, M_TRIG, M_CASC
  } mode_e;

  typedef enum logic [2:0] {
    A_CTRL, A_CMP1, A_CMP2, A_LOAD, A_CNT, A_PRE1, A_PRE2, A_STAT
  } addr_e;

  typedef struct packed {
    logic [1:0] pl;
    logic [1:0] dbg;
    logic       down;
    logic [1:0] ssel;
    logic [3:0] psel;
    mode_e      mode;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/mtc_sync_edge.sv
module mtc_sync_edge #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      q      <= '0;
      q_prev <= '0;
    end else begin
      s1_q   <= d;
      q      <= s1_q;
      q_prev <= q;
    end
  end
endmodule

// File: rtl/mtc_prescale.sv
module mtc_prescale #(
  parameter int NSEL = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(NSEL)-1:0] sel,
  output logic                    tick
);
  localparam int PW = (NSEL > 1) ? NSEL - 1 : 1;

  logic [PW-1:0]   pre_q;
  logic [PW-1:0]   pre_d;
  logic [NSEL-1:0] tick_v;

  assign pre_d = pre_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  for (genvar k = 0; k < NSEL; k++) begin : g_div
    if (k == 0) begin : g_one
      assign tick_v[k] = 1'b1;
    end else begin : g_pow
      assign tick_v[k] = &pre_q[k-1:0];
    end
  end

  assign tick = tick_v[sel];
endmodule

// File: rtl/mtc_mode_ctrl.sv
module mtc_mode_ctrl
  import mtc_pkg::*;
(
  input  mode_e mode,
  input  logic  prim_cur,
  input  logic  prim_prv,
  input  logic  sec_cur,
  input  logic  sec_prv,
  input  logic  down_cfg,
  input  logic  trig_run,
  output logic  en,
  output logic  up
);
  logic p_rise, p_fall, q_fwd, q_back;
  logic [1:0] q_prev, q_cur;

  assign p_rise = prim_cur & ~prim_prv;
  assign p_fall = ~prim_cur & prim_prv;
  assign q_prev = {prim_prv, sec_prv};
  assign q_cur  = {prim_cur, sec_cur};
  assign q_fwd  = (q_cur == {~q_prev[0], q_prev[1]});
  assign q_back = (q_cur == {q_prev[0], ~q_prev[1]});

  always_comb begin
    en = 1'b0;
    up = ~down_cfg;
    unique case (mode)
      M_OFF:    en = 1'b0;
      M_RISE:   en = p_rise;
      M_BOTH:   en = p_rise | p_fall;
      M_GATED:  en = p_rise & sec_cur;
      M_QUAD: begin
        en = q_fwd | q_back;
        up = q_fwd;
      end
      M_DIRSEC: begin
        en = p_rise;
        up = ~sec_cur;
      end
      M_TRIG:   en = p_rise & trig_run;
      M_CASC:   en = prim_cur;
      default:  en = 1'b0;
    endcase
  end
endmodule

// File: rtl/mtc_channel.sv
module mtc_channel
  import mtc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  input  logic [3:0]    pin_in,
  input  logic [3:0]    sib_in,
  input  logic          dbg_req,
  output logic          cmp_out,
  output logic          irq
);
  localparam logic [CW-1:0] ALL_ONES = {CW{1'b1}};

  logic rs1_q, rs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs_n  <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs_n  <= rs1_q;
    end
  end

  ctrl_t               ctrl_q, ctrl_d;
  logic [CW-1:0]       cmp1_q, cmp1_d, cmp2_q, cmp2_d, load_q, load_d;
  logic [CW-1:0]       cnt_q, cnt_d, pre1_q, pre1_d, pre2_q, pre2_d;
  logic [FLAG_N-1:0]   flags_q, flags_d, ie_q, ie_d, flag_set;
  logic                trig_q, trig_d, cmpo_d;
  logic [SIB_N-1:0]    sib_p;
  logic [PIN_N-1:0]    pin_s, pin_p;
  logic                tick, prim_cur, prim_prv, sec_cur, sec_prv, sec_rise;
  logic                en, up, halt, step, match;

  mtc_sync_edge #(.W(PIN_N)) u_sync (
    .clk(clk), .rst_n(rs_n), .d(pin_in), .q(pin_s), .q_prev(pin_p)
  );

  mtc_prescale #(.NSEL(DIV_N)) u_pre (
    .clk(clk), .rst_n(rs_n), .sel(ctrl_q.psel[2:0]), .tick(tick)
  );

  always_comb begin
    if (ctrl_q.psel[3]) begin
      prim_cur = tick;
      prim_prv = 1'b0;
    end else if (ctrl_q.psel[2]) begin
      prim_cur = sib_in[ctrl_q.psel[1:0]];
      prim_prv = sib_p[ctrl_q.psel[1:0]];
    end else begin
      prim_cur = pin_s[ctrl_q.psel[1:0]];
      prim_prv = pin_p[ctrl_q.psel[1:0]];
    end
  end

  assign sec_cur  = pin_s[ctrl_q.ssel];
  assign sec_prv  = pin_p[ctrl_q.ssel];
  assign sec_rise = sec_cur & ~sec_prv;

  mtc_mode_ctrl u_mode (
    .mode(ctrl_q.mode), .prim_cur(prim_cur), .prim_prv(prim_prv),
    .sec_cur(sec_cur), .sec_prv(sec_prv), .down_cfg(ctrl_q.down),
    .trig_run(trig_q), .en(en), .up(up)
  );

  assign halt  = dbg_req & ctrl_q.dbg[0];
  assign step  = en & ~halt;
  assign match = up ? (cnt_q == cmp1_q) : (cnt_q == cmp2_q);

  always_comb begin
    ctrl_d   = ctrl_q;
    cmp1_d   = cmp1_q;
    cmp2_d   = cmp2_q;
    load_d   = load_q;
    cnt_d    = cnt_q;
    pre1_d   = pre1_q;
    pre2_d   = pre2_q;
    ie_d     = ie_q;
    flag_set = '0;

    flag_set[F_EDGE] = sec_rise;
    if (step) begin
      if (match) begin
        cnt_d            = load_q;
        flag_set[F_CMP]  = 1'b1;
        flag_set[F_CMP1] = up;
        flag_set[F_CMP2] = ~up;
        if ((ctrl_q.pl == 2'd1 && up) || (ctrl_q.pl == 2'd2 && !up)) begin
          cmp1_d = pre1_q;
          cmp2_d = pre2_q;
        end
      end else begin
        cnt_d           = up ? cnt_q + 1'b1 : cnt_q - 1'b1;
        flag_set[F_OVF] = up ? (cnt_q == ALL_ONES) : (cnt_q == '0);
      end
    end

    trig_d = (ctrl_q.mode == M_TRIG) && ((trig_q && !(step && match)) || sec_rise);
    cmpo_d = step & match & ~(dbg_req & ctrl_q.dbg[1]);
    flags_d = flags_q | flag_set;

    if (wr_en) begin
      unique case (addr_e'(addr))
        A_CTRL: ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
        A_CMP1: cmp1_d = wdata;
        A_CMP2: cmp2_d = wdata;
        A_LOAD: load_d = wdata;
        A_CNT:  cnt_d  = wdata;
        A_PRE1: pre1_d = wdata;
        A_PRE2: pre2_d = wdata;
        A_STAT: begin
          ie_d    = wdata[IE_LSB +: FLAG_N];
          flags_d = (flags_q & ~wdata[FLAG_N-1:0]) | flag_set;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      ctrl_q  <= '0;
      cmp1_q  <= '0;
      cmp2_q  <= '0;
      load_q  <= '0;
      cnt_q   <= '0;
      pre1_q  <= '0;
      pre2_q  <= '0;
      flags_q <= '0;
      ie_q    <= '0;
      trig_q  <= 1'b0;
      cmp_out <= 1'b0;
      sib_p   <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      cmp1_q  <= cmp1_d;
      cmp2_q  <= cmp2_d;
      load_q  <= load_d;
      cnt_q   <= cnt_d;
      pre1_q  <= pre1_d;
      pre2_q  <= pre2_d;
      flags_q <= flags_d;
      ie_q    <= ie_d;
      trig_q  <= trig_d;
      cmp_out <= cmpo_d;
      sib_p   <= sib_in;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr_e'(addr))
      A_CTRL: rdata[CTRL_W-1:0] = ctrl_q;
      A_CMP1: rdata = cmp1_q;
      A_CMP2: rdata = cmp2_q;
      A_LOAD: rdata = load_q;
      A_CNT:  rdata = cnt_q;
      A_PRE1: rdata = pre1_q;
      A_PRE2: rdata = pre2_q;
      A_STAT: begin
        rdata[FLAG_N-1:0]        = flags_q;
        rdata[IE_LSB +: FLAG_N]  = ie_q;
      end
      default: rdata = '0;
    endcase
  end

  assign irq = |(flags_q & ie_q);
endmodule

// File: rtl/mtc_channel_chk.sv
module mtc_channel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  addr,
  input logic [15:0] wdata,
  input logic        dbg_req,
  input logic        cmp_out,
  input logic [15:0] cnt_q,
  input logic [15:0] load_q,
  input logic [13:0] ctrl_q,
  input logic [4:0]  flags_q
);
  logic cnt_wr;
  assign cnt_wr = wr_en && (addr == 3'd4);

  assert_stopped_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[2:0] == 3'd0 && !cnt_wr) |=> $stable(cnt_q));

  assert_halt_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && ctrl_q[10] && !cnt_wr) |=> $stable(cnt_q));

  assert_force_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_req && ctrl_q[11]) |=> !cmp_out);

  assert_step_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 16'd1 ||
                 cnt_q == $past(cnt_q) - 16'd1 || cnt_q == $past(load_q)));

  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[3] && !(wr_en && addr == 3'd7 && wdata[3])) |=> flags_q[3]);

  assert_cmp_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[0] && !(wr_en && addr == 3'd7 && wdata[0])) |=> flags_q[0]);
endmodule

bind mtc_channel mtc_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .dbg_req(dbg_req), .cmp_out(cmp_out), .cnt_q(cnt_q), .load_q(load_q),
  .ctrl_q(ctrl_q), .flags_q(flags_q)
);

// File: tb/mtc_channel_bench.sv
module mtc_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd4;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  pin_in = '0;
  logic [3:0]  sib_in = '0;
  logic        dbg_req = 1'b0;
  logic        cmp_out, irq;

  int    n_chk = 0, n_err = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #4 clk = ~clk;

  mtc_channel u_mtc_channel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .sib_in(sib_in), .dbg_req(dbg_req),
    .cmp_out(cmp_out), .irq(irq)
  );

  // behavioural reference state
  bit          m_rs1, m_rs2, m_trig, m_cmpo;
  logic [3:0]  m_s1, m_s2, m_pv, m_sibp;
  int          m_pre;
  logic [13:0] m_ctrl;
  logic [15:0] m_cmp1, m_cmp2, m_load, m_cnt, m_p1, m_p2;
  logic [4:0]  m_flags, m_ie;

  function automatic int gray_pos(int v);
    case (v)
      0: return 0;
      2: return 1;
      3: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic m_clear();
    m_trig = 0; m_cmpo = 0; m_s1 = 0; m_s2 = 0; m_pv = 0; m_sibp = 0; m_pre = 0;
    m_ctrl = 0; m_cmp1 = 0; m_cmp2 = 0; m_load = 0; m_cnt = 0; m_p1 = 0; m_p2 = 0;
    m_flags = 0; m_ie = 0;
  endtask

  task automatic m_step();
    int mode = int'(m_ctrl[2:0]);
    int psel = int'(m_ctrl[6:3]);
    int ssel = int'(m_ctrl[8:7]);
    bit dn = m_ctrl[9];
    int pl = int'(m_ctrl[13:12]);
    bit pc, pp, sc, sp, en, up, st, mt, srise;
    int qi, qj;
    logic [15:0] n_cnt = m_cnt, n_c1 = m_cmp1, n_c2 = m_cmp2;
    logic [4:0]  setf = 0;
    if (psel < 4) begin pc = m_s2[psel]; pp = m_pv[psel]; end
    else if (psel < 8) begin pc = sib_in[psel-4]; pp = m_sibp[psel-4]; end
    else begin
      int k = psel - 8;
      pc = ((m_pre % (1 << k)) == (1 << k) - 1);
      pp = 0;
    end
    sc = m_s2[ssel]; sp = m_pv[ssel];
    srise = sc && !sp;
    up = !dn; en = 0;
    case (mode)
      1: en = pc && !pp;
      2: en = pc != pp;
      3: en = pc && !pp && sc;
      4: begin
        qi = gray_pos({pp, sp}); qj = gray_pos({pc, sc});
        en = (qj == (qi + 1) % 4) || (qj == (qi + 3) % 4);
        up = (qj == (qi + 1) % 4);
      end
      5: begin en = pc && !pp; up = !sc; end
      6: en = pc && !pp && m_trig;
      7: en = pc;
      default: en = 0;
    endcase
    st = en && !(dbg_req && m_ctrl[10]);
    mt = up ? (m_cnt == m_cmp1) : (m_cnt == m_cmp2);
    if (srise) setf[4] = 1;
    if (st && mt) begin
      n_cnt = m_load; setf[0] = 1;
      if (up) setf[1] = 1; else setf[2] = 1;
      if ((pl == 1 && up) || (pl == 2 && !up)) begin n_c1 = m_p1; n_c2 = m_p2; end
    end else if (st) begin
      if (up) begin n_cnt = m_cnt + 16'd1; if (m_cnt == 16'hFFFF) setf[3] = 1; end
      else    begin n_cnt = m_cnt - 16'd1; if (m_cnt == 16'h0000) setf[3] = 1; end
    end
    m_trig = (mode == 6) && ((m_trig && !(st && mt)) || srise);
    m_cmpo = st && mt && !(dbg_req && m_ctrl[11]);
    m_flags = m_flags | setf;
    if (wr_en) begin
      case (addr)
        3'd0: m_ctrl = wdata[13:0];
        3'd1: n_c1 = wdata;
        3'd2: n_c2 = wdata;
        3'd3: m_load = wdata;
        3'd4: n_cnt = wdata;
        3'd5: m_p1 = wdata;
        3'd6: m_p2 = wdata;
        default: begin
          m_ie = wdata[12:8];
          m_flags = (m_flags & ~wdata[4:0]) | setf;
        end
      endcase
    end
    m_cnt = n_cnt; m_cmp1 = n_c1; m_cmp2 = n_c2;
    m_pv = m_s2; m_s2 = m_s1; m_s1 = pin_in; m_sibp = sib_in;
    m_pre = (m_pre + 1) % 128;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0; m_clear();
    end else if (!m_rs2) begin
      m_clear(); m_rs2 = m_rs1; m_rs1 = 1;
    end else begin
      m_step();
    end
  end

  function automatic logic [15:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return {2'b00, m_ctrl};
      3'd1: return m_cmp1;
      3'd2: return m_cmp2;
      3'd3: return m_load;
      3'd4: return m_cnt;
      3'd5: return m_p1;
      3'd6: return m_p2;
      default: return {3'b000, m_ie, 3'b000, m_flags};
    endcase
  endfunction

  task automatic check(bit ok, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(rdata === m_read(addr), "rdata", rdata, m_read(addr));
      check(irq === |(m_flags & m_ie), "irq", {15'd0, irq}, {15'd0, |(m_flags & m_ie)});
      check(cmp_out === m_cmpo, "cmp_out", {15'd0, cmp_out}, {15'd0, m_cmpo});
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    cyc(1);
    wr_en = 1'b0; addr = 3'd4;
  endtask

  function automatic logic [15:0] ctl(int mode, int psel, int ssel, int dn, int dbg, int pl);
    return 16'((pl << 12) | (dbg << 10) | (dn << 9) | (ssel << 7) | (psel << 3) | mode);
  endfunction

  task automatic quad(bit p, bit s);
    pin_in[0] = p; pin_in[1] = s;
    cyc(4);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    cur_req = "R1"; cyc(3);
    rst_n = 1'b1; cyc(4);
    for (int a = 0; a < 8; a++) begin addr = 3'(a); cyc(1); end
    addr = 3'd4;

    cur_req = "R9";
    wr(3'd1, 16'd5); wr(3'd3, 16'd2);
    wr(3'd0, ctl(1, 8, 0, 0, 0, 0)); cyc(20);

    cur_req = "R11";
    wr(3'd7, 16'h1F00); cyc(3);
    addr = 3'd7; cyc(2);
    wr(3'd7, 16'h1F1F); addr = 3'd7; cyc(3);

    cur_req = "R2";
    wr(3'd0, ctl(0, 9, 2, 1, 2, 1)); addr = 3'd0; cyc(2);
    addr = 3'd4; cyc(6);

    cur_req = "R3";
    wr(3'd1, 16'd1000);
    wr(3'd0, ctl(1, 10, 0, 0, 0, 0)); cyc(40);
    wr(3'd0, ctl(1, 0, 0, 0, 0, 0));
    for (int i = 0; i < 8; i++) begin pin_in[0] = ~pin_in[0]; cyc(3); end
    wr(3'd0, ctl(1, 5, 0, 0, 0, 0));
    for (int i = 0; i < 5; i++) begin sib_in[1] = 1'b1; cyc(1); sib_in[1] = 1'b0; cyc(2); end

    cur_req = "R4";
    wr(3'd0, ctl(2, 1, 0, 0, 0, 0));
    for (int i = 0; i < 6; i++) begin pin_in[1] = ~pin_in[1]; cyc(4); end
    wr(3'd0, ctl(3, 0, 2, 0, 0, 0));
    pin_in[2] = 1'b1;
    for (int i = 0; i < 6; i++) begin pin_in[0] = ~pin_in[0]; cyc(4); end
    pin_in[2] = 1'b0;
    for (int i = 0; i < 6; i++) begin pin_in[0] = ~pin_in[0]; cyc(4); end

    cur_req = "R5";
    pin_in = '0; cyc(4);
    wr(3'd4, 16'd10); wr(3'd2, 16'd3); wr(3'd1, 16'd100);
    wr(3'd0, ctl(4, 0, 1, 0, 0, 0));
    quad(1, 0); quad(1, 1); quad(0, 1); quad(0, 0); quad(1, 0);
    quad(0, 0); quad(0, 1); quad(1, 1);
    quad(0, 0); quad(1, 1); quad(1, 0);

    cur_req = "R6";
    pin_in = '0; cyc(4);
    wr(3'd0, ctl(5, 0, 1, 0, 0, 0));
    for (int i = 0; i < 6; i++) begin pin_in[0] = ~pin_in[0]; cyc(3); end
    pin_in[1] = 1'b1;
    for (int i = 0; i < 8; i++) begin pin_in[0] = ~pin_in[0]; cyc(3); end

    cur_req = "R7";
    pin_in = '0; cyc(4);
    wr(3'd4, 16'd0); wr(3'd1, 16'd8); wr(3'd3, 16'd0);
    wr(3'd0, ctl(6, 8, 2, 0, 0, 0)); cyc(10);
    pin_in[2] = 1'b1; cyc(25);
    pin_in[2] = 1'b0; cyc(4);
    pin_in[2] = 1'b1; cyc(6);

    cur_req = "R8";
    wr(3'd4, 16'd0); wr(3'd1, 16'd4);
    wr(3'd0, ctl(7, 4, 0, 0, 0, 0));
    sib_in[0] = 1'b1; cyc(7); sib_in[0] = 1'b0; cyc(3);
    wr(3'd2, 16'd0); wr(3'd0, ctl(7, 4, 0, 1, 0, 0));
    sib_in[0] = 1'b1; cyc(4); sib_in[0] = 1'b0; cyc(2);

    cur_req = "R9";
    wr(3'd4, 16'd2); wr(3'd2, 16'h8000); wr(3'd3, 16'd7);
    wr(3'd0, ctl(1, 8, 0, 1, 0, 0)); cyc(6);
    wr(3'd4, 16'hFFFE); wr(3'd1, 16'd3);
    wr(3'd0, ctl(1, 8, 0, 0, 0, 0)); cyc(6);
    addr = 3'd7; cyc(2); addr = 3'd4;

    cur_req = "R10";
    wr(3'd5, 16'd3); wr(3'd6, 16'd9); wr(3'd1, 16'd4);
    wr(3'd3, 16'd0); wr(3'd4, 16'd0);
    wr(3'd0, ctl(1, 8, 0, 0, 0, 1)); cyc(16);
    addr = 3'd1; cyc(2); addr = 3'd2; cyc(2); addr = 3'd4;
    wr(3'd5, 16'd6); wr(3'd0, ctl(1, 8, 0, 0, 0, 0)); cyc(12);
    addr = 3'd1; cyc(2); addr = 3'd4;

    cur_req = "R12";
    wr(3'd1, 16'd2); wr(3'd4, 16'd0);
    wr(3'd0, ctl(1, 8, 0, 0, 3, 0)); cyc(6);
    dbg_req = 1'b1; cyc(6); dbg_req = 1'b0; cyc(6);
    wr(3'd0, ctl(1, 8, 0, 0, 2, 0));
    dbg_req = 1'b1; cyc(10); dbg_req = 1'b0; cyc(4);

    cur_req = "R11";
    wr(3'd7, 16'h081F); addr = 3'd7; cyc(3);
    wr(3'd7, 16'h0800); addr = 3'd7; cyc(3); addr = 3'd4;

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule